// File: doc/BRIEF.md
# Bank Access Key Guard

The guard sits beside the memory banking logic of a small processor system with sixteen 64 KB banks. Each bank carries an 8-bit access key. A key of zero marks the bank as supervisor memory. Any nonzero key marks it as user memory. Banks that share a nonzero key form one isolation group. The guard follows the privilege mode from three event strobes: subroutine call, subroutine return and interrupt. All three share one input that names the bank that becomes current. The guard also checks every data or fetch access against the key of the bank now executing.

Keys are written through a small write port, and only in supervisor mode. A write in user mode is dropped and flagged. A global protection-enable input switches the whole scheme on and off. While it is low, every access is granted and the mode falls back to supervisor. Access results come out one clock after the access: a grant pulse, or a fault pulse with no grant.

Top module: `bank_guard`

## Requirements
- R1: After reset the mode output is supervisor (`user_mode`=0), `acc_grant`, `acc_fault` and `kw_reject` are 0, and every bank key is 0, so a call into any bank leaves the mode supervisor.
- R2: A key write (`kw_valid`=1) accepted in supervisor mode stores `kw_key` for bank `kw_bank`, effective from the next clock.
- R3: A key write made while `user_mode`=1 is rejected: `kw_reject` is 1 for exactly the following cycle, and the stored key is unchanged.
- R4: While `prot_en`=0, every access is granted, `user_mode` is 0 from the next clock on, and no event can enter user mode.
- R5: With `prot_en`=1 in supervisor mode, a call (`call_stb`) to a bank whose key is nonzero sets `user_mode` at the next clock, and a call to a key-0 bank leaves it at 0.
- R6: In user mode, an access is granted only when the target bank's key equals the key of `exec_bank`; otherwise it faults.
- R7: In user mode, every access to a key-0 (supervisor) bank faults, with `acc_grant` held at 0.
- R8: In supervisor mode, an access to any bank is granted.
- R9: User mode is left only through a return (`ret_stb`) or an interrupt (`irq_stb`). After either event, `user_mode` becomes 1 exactly when the key of `evt_bank` is nonzero. A call made in user mode keeps user mode.
- R10: `acc_grant` or `acc_fault` is a single-cycle pulse in the cycle after an access (`acc_valid`=1). The two are never 1 together, and both are 0 when no access was made.
- R11: When a return or an interrupt strobe coincides with a call strobe, the return/interrupt rule of R9 decides the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_en | input | 1 | Global protection enable |
| kw_valid | input | 1 | Key write request |
| kw_bank | input | 4 | Bank whose key is written |
| kw_key | input | 8 | Key value to write |
| exec_bank | input | 4 | Bank the processor is executing from |
| acc_valid | input | 1 | Data or fetch access request |
| acc_bank | input | 4 | Bank targeted by the access |
| call_stb | input | 1 | Subroutine call event |
| ret_stb | input | 1 | Subroutine return event |
| irq_stb | input | 1 | Interrupt entry event |
| evt_bank | input | 4 | Bank that becomes current with the event |
| user_mode | output | 1 | 1 = user mode, 0 = supervisor mode |
| acc_grant | output | 1 | Access granted (one cycle after request) |
| acc_fault | output | 1 | Access denied (one cycle after request) |
| kw_reject | output | 1 | Key write rejected (one cycle after request) |

## Verification
The hardest case to reach is a rejected key write whose effect must be shown absent. The key table cannot be read, and writes are only refused in user mode, where key changes are visible only through access results. The bench first programs two banks with a shared key in supervisor mode. It then calls into one of them to enter user mode, attempts to give the other a new key, and checks that a cross-bank access is still granted. It also holds user mode across a call to a supervisor bank, and puts a return and a call in the same cycle, to test the exit rules.

// File: rtl/bank_guard_pkg.sv
package bank_guard_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CALL = 2'd1,
        EV_RET  = 2'd2,
        EV_IRQ  = 2'd3
    } evt_kind_e;

    // Interrupt and return outrank a call arriving in the same cycle.
    function automatic evt_kind_e resolve_evt(input logic call_s,
                                              input logic ret_s,
                                              input logic irq_s);
        if (irq_s)       return EV_IRQ;
        else if (ret_s)  return EV_RET;
        else if (call_s) return EV_CALL;
        else             return EV_NONE;
    endfunction

endpackage

// File: rtl/bg_key_store.sv
module bg_key_store #(
    parameter int NUM_BANKS = 16,
    parameter int KEY_W     = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [BANK_W-1:0]                wr_bank,
    input  logic [KEY_W-1:0]                 wr_key,
    output logic [NUM_BANKS-1:0][KEY_W-1:0]  keys_o
);

    typedef struct packed {
        logic [NUM_BANKS-1:0][KEY_W-1:0] keys;
    } store_t;

    store_t st_d, st_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            st_d.keys[b] = st_q.keys[b];
            if (wr_en && (wr_bank == BANK_W'(b))) begin
                st_d.keys[b] = wr_key;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign keys_o = st_q.keys;

    // R2: an accepted write lands in the addressed bank
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> keys_o[$past(wr_bank)] == $past(wr_key));

    // R3: without an accepted write the table holds
    a_r3_table_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(keys_o));

endmodule

// File: rtl/bg_mode_track.sv
module bg_mode_track
    import bank_guard_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_en,
    input  evt_kind_e         evt,
    input  logic [KEY_W-1:0]  evt_key,
    input  logic              kw_valid,
    output logic              wr_ok_o,
    output logic              user_o,
    output logic              kw_reject_o
);

    typedef struct packed {
        logic user;
        logic reject;
    } mode_t;

    mode_t md_d, md_q;
    logic  tgt_user;

    assign tgt_user = (evt_key != '0);

    always_comb begin
        md_d        = md_q;
        md_d.reject = kw_valid && md_q.user;
        if (!prot_en) begin
            md_d.user = 1'b0;
        end else begin
            unique case (evt)
                EV_RET, EV_IRQ: md_d.user = tgt_user;
                EV_CALL:        md_d.user = md_q.user || tgt_user;
                default:        md_d.user = md_q.user;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) md_q <= '0;
        else        md_q <= md_d;
    end

    assign user_o      = md_q.user;
    assign kw_reject_o = md_q.reject;
    assign wr_ok_o     = kw_valid && !md_q.user;

    // R4: disabled protection forces supervisor at the next edge
    a_r4_prot_off_sup: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |=> !user_o);

    // R9: only return or interrupt may leave user mode
    a_r9_user_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (user_o && prot_en && evt != EV_RET && evt != EV_IRQ) |=> user_o);

    // R3: user-mode write gives a reject pulse
    a_r3_reject_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (kw_valid && user_o) |=> kw_reject_o);

    // R2: supervisor write is never flagged
    a_r2_no_false_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (kw_valid && !user_o) |=> !kw_reject_o);

endmodule

// File: rtl/bg_access_check.sv
module bg_access_check #(
    parameter int KEY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_en,
    input  logic              user_mode,
    input  logic              acc_valid,
    input  logic [KEY_W-1:0]  acc_key,
    input  logic [KEY_W-1:0]  exec_key,
    output logic              grant_o,
    output logic              fault_o
);

    typedef struct packed {
        logic grant;
        logic fault;
    } chk_t;

    chk_t ck_d, ck_q;
    logic same_grp;
    logic allowed;

    assign same_grp = (acc_key != '0) && (acc_key == exec_key);

    always_comb begin
        allowed    = !prot_en || !user_mode || same_grp;
        ck_d.grant = acc_valid && allowed;
        ck_d.fault = acc_valid && !allowed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_q <= '0;
        else        ck_q <= ck_d;
    end

    assign grant_o = ck_q.grant;
    assign fault_o = ck_q.fault;

    // R10: grant and fault never together
    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && fault_o));

    // R10: no result without a request
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !grant_o && !fault_o);

    // R8: supervisor accesses always granted
    a_r8_sup_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !user_mode) |=> grant_o);

    // R7: user access to supervisor bank faults
    a_r7_sup_bank_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && user_mode && prot_en && acc_key == '0) |=> fault_o && !grant_o);

endmodule

// File: rtl/bank_guard.sv
module bank_guard
    import bank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    parameter int KEY_W     = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_en,
    input  logic              kw_valid,
    input  logic [BANK_W-1:0] kw_bank,
    input  logic [KEY_W-1:0]  kw_key,
    input  logic [BANK_W-1:0] exec_bank,
    input  logic              acc_valid,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic              call_stb,
    input  logic              ret_stb,
    input  logic              irq_stb,
    input  logic [BANK_W-1:0] evt_bank,
    output logic              user_mode,
    output logic              acc_grant,
    output logic              acc_fault,
    output logic              kw_reject
);

    logic [NUM_BANKS-1:0][KEY_W-1:0] keys;
    logic                            wr_ok;
    evt_kind_e                       evt;

    assign evt = resolve_evt(call_stb, ret_stb, irq_stb);

    bg_key_store #(.NUM_BANKS(NUM_BANKS), .KEY_W(KEY_W)) u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_bank (kw_bank),
        .wr_key  (kw_key),
        .keys_o  (keys)
    );

    bg_mode_track #(.KEY_W(KEY_W)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .prot_en     (prot_en),
        .evt         (evt),
        .evt_key     (keys[evt_bank]),
        .kw_valid    (kw_valid),
        .wr_ok_o     (wr_ok),
        .user_o      (user_mode),
        .kw_reject_o (kw_reject)
    );

    bg_access_check #(.KEY_W(KEY_W)) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_en   (prot_en),
        .user_mode (user_mode),
        .acc_valid (acc_valid),
        .acc_key   (keys[acc_bank]),
        .exec_key  (keys[exec_bank]),
        .grant_o   (acc_grant),
        .fault_o   (acc_fault)
    );

    // R5: supervisor call into a keyed bank enters user mode
    a_r5_call_enters_user: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && !user_mode && call_stb && !ret_stb && !irq_stb
         && keys[evt_bank] != '0) |=> user_mode);

    // R11: return/interrupt to a key-0 bank leaves user mode despite a call
    a_r11_exit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && (ret_stb || irq_stb) && keys[evt_bank] == '0) |=> !user_mode);

endmodule

// File: tb/bank_guard_tb.sv
module bank_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prot_en = 1'b0;
    logic       kw_valid = 1'b0;
    logic [3:0] kw_bank = '0;
    logic [7:0] kw_key = '0;
    logic [3:0] exec_bank = '0;
    logic       acc_valid = 1'b0;
    logic [3:0] acc_bank = '0;
    logic       call_stb = 1'b0;
    logic       ret_stb = 1'b0;
    logic       irq_stb = 1'b0;
    logic [3:0] evt_bank = '0;
    logic       user_mode, acc_grant, acc_fault, kw_reject;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bank_guard u_dut (
        .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
        .kw_valid(kw_valid), .kw_bank(kw_bank), .kw_key(kw_key),
        .exec_bank(exec_bank), .acc_valid(acc_valid), .acc_bank(acc_bank),
        .call_stb(call_stb), .ret_stb(ret_stb), .irq_stb(irq_stb),
        .evt_bank(evt_bank), .user_mode(user_mode), .acc_grant(acc_grant),
        .acc_fault(acc_fault), .kw_reject(kw_reject)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // one clock: inputs set after a negedge, outputs seen at the next negedge
    task automatic tick();
        @(negedge clk);
        kw_valid = 1'b0; acc_valid = 1'b0;
        call_stb = 1'b0; ret_stb = 1'b0; irq_stb = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] b, input logic [7:0] k);
        kw_valid = 1'b1; kw_bank = b; kw_key = k; tick();
    endtask

    task automatic do_call(input logic [3:0] b);
        call_stb = 1'b1; evt_bank = b; tick();
    endtask

    task automatic do_acc(input logic [3:0] b);
        acc_valid = 1'b1; acc_bank = b; tick();
    endtask

    task automatic t_reset();
        chk("R1 mode", user_mode, 1'b0);
        chk("R1 grant", acc_grant, 1'b0);
        chk("R1 fault", acc_fault, 1'b0);
        chk("R1 reject", kw_reject, 1'b0);
        prot_en = 1'b1;
        do_call(4'd2);
        chk("R1 keys zero, call stays sup", user_mode, 1'b0);
    endtask

    task automatic t_supervisor();
        do_write(4'd3, 8'd5);
        chk("R2 no reject", kw_reject, 1'b0);
        do_write(4'd4, 8'd5);
        do_write(4'd7, 8'd9);
        for (int b = 0; b < 16; b += 5) begin
            do_acc(4'(b));
            chk("R8 sup grant", acc_grant, 1'b1);
            chk("R8 sup no fault", acc_fault, 1'b0);
        end
    endtask

    task automatic t_call();
        do_call(4'd0);
        chk("R5 call key0 stays sup", user_mode, 1'b0);
        do_call(4'd3);
        chk("R5 R2 call keyed enters user", user_mode, 1'b1);
    endtask

    task automatic t_user_access();
        exec_bank = 4'd3;
        do_acc(4'd4);
        chk("R6 same key grant", acc_grant, 1'b1);
        do_acc(4'd7);
        chk("R6 other key fault", acc_fault, 1'b1);
        chk("R6 other key no grant", acc_grant, 1'b0);
        do_acc(4'd0);
        chk("R7 sup bank fault", acc_fault, 1'b1);
        chk("R7 sup bank no grant", acc_grant, 1'b0);
        tick();
        chk("R10 fault one cycle", acc_fault, 1'b0);
        chk("R10 no grant idle", acc_grant, 1'b0);
    endtask

    task automatic t_reject();
        do_write(4'd4, 8'd9);
        chk("R3 reject pulse", kw_reject, 1'b1);
        tick();
        chk("R3 reject one cycle", kw_reject, 1'b0);
        do_acc(4'd4);
        chk("R3 key unchanged", acc_grant, 1'b1);
    endtask

    task automatic t_exit();
        do_call(4'd0);
        chk("R9 user call keeps user", user_mode, 1'b1);
        ret_stb = 1'b1; evt_bank = 4'd0; tick();
        chk("R9 ret to key0 sup", user_mode, 1'b0);
        do_call(4'd7);
        chk("R9 enter user again", user_mode, 1'b1);
        irq_stb = 1'b1; evt_bank = 4'd4; tick();
        chk("R9 irq to keyed bank user", user_mode, 1'b1);
        irq_stb = 1'b1; evt_bank = 4'd1; tick();
        chk("R9 irq to key0 sup", user_mode, 1'b0);
    endtask

    task automatic t_priority();
        do_call(4'd3);
        ret_stb = 1'b1; call_stb = 1'b1; evt_bank = 4'd0; tick();
        chk("R11 ret beats call", user_mode, 1'b0);
    endtask

    task automatic t_prot_off();
        do_call(4'd3);
        exec_bank = 4'd3;
        prot_en = 1'b0;
        do_acc(4'd0);
        chk("R4 access granted", acc_grant, 1'b1);
        chk("R4 mode sup", user_mode, 1'b0);
        do_call(4'd7);
        chk("R4 call no user", user_mode, 1'b0);
        prot_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_supervisor();
        t_call();
        t_user_access();
        t_reject();
        t_exit();
        t_priority();
        t_prot_off();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #50000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule